// File: doc/BRIEF.md
# Acquisition Trigger Qualifier

This block decides when a sampling engine may issue conversions. Software raises a start command; in software mode the run-enable output follows at once, while in hardware mode the block waits for an asynchronous TTL trigger input to qualify. The run-enable output gates the sample pacer, which lives outside this block together with the converter and the sample storage.

The trigger input is brought into the clock domain through a synchroniser chain. Edge detection then runs on the synchronised copy. In edge mode the first qualifying edge seen after start latches acquisition on for as long as start stays high. In level mode the same kind of fresh transition arms the block, and from then on the trigger level pauses and resumes acquisition. Any trigger activity before start is ignored, including a level that is already active when start rises. A one-cycle pulse marks the moment the trigger condition is first met.

Top module: `acq_trig_qual`

## Requirements
- R1: While reset is held and on the first cycle after it, run_en_o and trig_hit_o are 0.
- R2: With hw_mode_i = 0, run_en_o is 1 from the first clock edge after start_i rises, and no trigger activity changes it while start_i stays high.
- R3: In edge mode (level_mode_i = 0, hw_mode_i = 1), dir_i selects the qualifying edge: 2'b00 falling only, 2'b01 rising only, 2'b10 or 2'b11 either edge. Only a qualifying edge sets run_en_o.
- R4: In edge mode, once run_en_o is set, later changes of the trigger input leave it at 1 until start_i falls.
- R5: In hardware mode, trigger edges or levels present before start_i rises do not enable acquisition. A level already active at start needs a fresh transition into the active level.
- R6: In level mode with dir_i = 2'b01 (high active) or 2'b00 (low active), after arming by a transition into the active level, run_en_o is 1 exactly while the synchronised trigger is at the active level, pausing and resuming without re-arming.
- R7: In level mode with dir_i = 2'b10 or 2'b11, the block behaves as in software mode.
- R8: When start_i falls, run_en_o is 0 one clock edge later and the armed state is cleared, so a new start needs a new qualification.
- R9: trig_hit_o is a single-cycle pulse, coincident with the first cycle of run_en_o after each start, and never otherwise.
- R10: A trigger change driven before clock edge 1 shows on run_en_o after clock edge SYNC_STAGES+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Software start command, held high while acquiring |
| hw_mode_i | input | 1 | 0 software start, 1 wait for the trigger input |
| level_mode_i | input | 1 | 0 edge qualification, 1 level gating |
| dir_i | input | 2 | Direction: 00 falling/low, 01 rising/high, 1x both |
| trig_async_i | input | 1 | Asynchronous TTL trigger input |
| run_en_o | output | 1 | Run-enable to the sample pacer |
| trig_hit_o | output | 1 | One-cycle pulse when the trigger condition is first met |

## Verification
Both outputs are registered. A start or stop command shows on them one clock edge later. A trigger change shows only after SYNC_STAGES edges in the synchroniser and one more in the control register. The bench drives every input on the falling clock edge. After a trigger change it samples at the falling edge following rising edge SYNC_STAGES, expecting the old value, and again one edge later, expecting the new value and the hit pulse. One further edge later it checks that the pulse has gone. A start check is taken one edge after start rises and a stop check one edge after it falls. Before each start the trigger is left settled for several cycles, so no edge from the previous case is still in flight.

// File: rtl/acq_trig_pkg.sv
`timescale 1ns/1ps
package acq_trig_pkg;
   typedef enum logic [1:0] {
      TDIR_NEG  = 2'b00,
      TDIR_POS  = 2'b01,
      TDIR_BOTH = 2'b10,
      TDIR_ANY  = 2'b11
   } trig_dir_e;

   typedef enum logic [1:0] {
      QS_IDLE = 2'b00,
      QS_WAIT = 2'b01,
      QS_RUN  = 2'b10
   } qual_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/acq_trig_sync.sv
`timescale 1ns/1ps
module acq_trig_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= IDLE_VAL;
               else        chain_q[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= IDLE_VAL;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/acq_trig_edge.sv
`timescale 1ns/1ps
module acq_trig_edge #(
   parameter bit IDLE_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
`timescale 1ns/1ps
module acq_trig_ctrl
   import acq_trig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       hw_mode_i,
   input  logic       level_mode_i,
   input  logic [1:0] dir_i,
   input  logic       lvl_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic       run_en_o,
   output logic       hit_o
);
   qual_state_e state_q, state_d;
   trig_dir_e   dir;
   logic        both_dir, qual_edge, sw_like, lvl_active;
   logic        run_d, hit_d, run_q, hit_q;

   always_comb begin
      dir        = trig_dir_e'(dir_i);
      both_dir   = (dir == TDIR_BOTH) || (dir == TDIR_ANY);
      unique case (dir)
         TDIR_NEG: qual_edge = fall_i;
         TDIR_POS: qual_edge = rise_i;
         default:  qual_edge = rise_i | fall_i;
      endcase
      sw_like    = !hw_mode_i || (level_mode_i && both_dir);
      lvl_active = !level_mode_i || (lvl_i == dir_i[0]);
   end

   always_comb begin
      state_d = state_q;
      if (!start_i) begin
         state_d = QS_IDLE;
      end else begin
         unique case (state_q)
            QS_IDLE: state_d = sw_like ? QS_RUN : QS_WAIT;
            QS_WAIT: if (qual_edge || sw_like) state_d = QS_RUN;
            default: state_d = QS_RUN;
         endcase
      end
      run_d = start_i && (state_d == QS_RUN) && (sw_like || lvl_active);
      hit_d = start_i && (state_d == QS_RUN) && (state_q != QS_RUN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= QS_IDLE;
         run_q   <= 1'b0;
         hit_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         run_q   <= run_d;
         hit_q   <= hit_d;
      end
   end

   assign run_en_o = run_q;
   assign hit_o    = hit_q;
endmodule

// File: rtl/acq_trig_qual.sv
`timescale 1ns/1ps
module acq_trig_qual
   import acq_trig_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TRIG_IDLE   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       hw_mode_i,
   input  logic       level_mode_i,
   input  logic [1:0] dir_i,
   input  logic       trig_async_i,
   output logic       run_en_o,
   output logic       trig_hit_o
);
   generate
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
         $error("acq_trig_qual: SYNC_STAGES below minimum");
      end
   endgenerate

   logic trig_sync, trig_rise, trig_fall;

   acq_trig_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(TRIG_IDLE)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (trig_async_i),
      .q_o   (trig_sync)
   );

   acq_trig_edge #(.IDLE_VAL(TRIG_IDLE)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (trig_sync),
      .rise_o (trig_rise),
      .fall_o (trig_fall)
   );

   acq_trig_ctrl ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .hw_mode_i    (hw_mode_i),
      .level_mode_i (level_mode_i),
      .dir_i        (dir_i),
      .lvl_i        (trig_sync),
      .rise_i       (trig_rise),
      .fall_i       (trig_fall),
      .run_en_o     (run_en_o),
      .hit_o        (trig_hit_o)
   );
endmodule

// File: rtl/acq_trig_qual_chk.sv
`timescale 1ns/1ps
module acq_trig_qual_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       hw_mode_i,
   input logic       level_mode_i,
   input logic [1:0] dir_i,
   input logic       run_en_o,
   input logic       trig_hit_o
);
   assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!run_en_o && !trig_hit_o));

   assert_sw_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !hw_mode_i) |=> run_en_o);

   assert_level_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && hw_mode_i && level_mode_i && dir_i[1]) |=> run_en_o);

   assert_edge_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_o && start_i && hw_mode_i && !level_mode_i) |=> run_en_o);

   assert_hit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit_o |=> !trig_hit_o);

   assert_hit_with_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit_o |-> run_en_o);

   assert_hit_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_o && start_i) |=> !trig_hit_o);
endmodule

bind acq_trig_qual acq_trig_qual_chk chk_i (.*);

// File: tb/acq_trig_qual_tb_top.sv
`timescale 1ns/1ps
module acq_trig_qual_tb_top;
   localparam int unsigned NS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       hw_mode_i = 1'b0;
   logic       level_mode_i = 1'b0;
   logic [1:0] dir_i = 2'b00;
   logic       trig_async_i = 1'b0;
   logic       run_en_o, trig_hit_o;

   int checks = 0;
   int errors = 0;

   // model of the requirements
   logic m_armed, m_sw_like, m_trig;

   always #2.5 clk = ~clk;

   acq_trig_qual #(.SYNC_STAGES(NS), .TRIG_IDLE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .hw_mode_i(hw_mode_i),
      .level_mode_i(level_mode_i), .dir_i(dir_i), .trig_async_i(trig_async_i),
      .run_en_o(run_en_o), .trig_hit_o(trig_hit_o)
   );

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_run(input logic v);
      if (m_sw_like) return 1'b1;
      if (!m_armed) return 1'b0;
      if (!level_mode_i) return 1'b1;
      return v == dir_i[0];
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic toggle(input logic v);
      logic e0, e1, qual, hit;
      string tag;
      e0 = exp_run(m_trig);
      qual = dir_i[1] || (dir_i[0] ? v : !v);
      hit = 1'b0;
      tag = m_sw_like ? (hw_mode_i ? "R7" : "R2") :
            (!level_mode_i ? (m_armed ? "R4" : "R3") : "R6");
      if (!m_sw_like && !m_armed && qual) begin
         m_armed = 1'b1;
         hit = 1'b1;
      end
      m_trig = v;
      e1 = exp_run(v);
      trig_async_i = v;
      repeat (NS) tick();
      check("R10", run_en_o, e0, "run before sync latency");
      tick();
      check(tag, run_en_o, e1, "run after trigger change");
      check("R9", trig_hit_o, hit, "hit on qualification");
      tick();
      check("R9", trig_hit_o, 1'b0, "hit one cycle");
   endtask

   task automatic run_case(input logic hw, input logic lvl, input logic [1:0] dir, input logic init);
      hw_mode_i = hw;
      level_mode_i = lvl;
      dir_i = dir;
      trig_async_i = init;
      m_trig = init;
      m_armed = 1'b0;
      m_sw_like = !hw || (lvl && dir[1]);
      // pre-start trigger activity must be ignored (R5)
      repeat (NS + 3) tick();
      trig_async_i = !init;
      repeat (NS + 3) tick();
      trig_async_i = init;
      repeat (NS + 3) tick();
      check("R8", run_en_o, 1'b0, "idle before start");
      start_i = 1'b1;
      tick();
      check(m_sw_like ? (hw ? "R7" : "R2") : "R5", run_en_o, m_sw_like, "run at start");
      check("R9", trig_hit_o, m_sw_like, "hit at start");
      tick();
      check("R9", trig_hit_o, 1'b0, "hit one cycle at start");
      check("R5", run_en_o, m_sw_like, "no stale trigger");
      toggle(!init);
      toggle(init);
      toggle(!init);
      start_i = 1'b0;
      tick();
      check("R8", run_en_o, 1'b0, "stop clears run");
      check("R8", trig_hit_o, 1'b0, "stop clears hit");
   endtask

   initial begin
      rst_n = 1'b0;
      start_i = 1'b1;
      repeat (3) tick();
      check("R1", run_en_o, 1'b0, "run in reset");
      check("R1", trig_hit_o, 1'b0, "hit in reset");
      start_i = 1'b0;
      rst_n = 1'b1;
      tick();
      check("R1", run_en_o, 1'b0, "run after reset");
      check("R1", trig_hit_o, 1'b0, "hit after reset");
      for (int h = 0; h < 2; h++)
         for (int l = 0; l < 2; l++)
            for (int d = 0; d < 4; d++)
               for (int i = 0; i < 2; i++)
                  run_case(h[0], l[0], d[1:0], i[0]);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog run_en=%b expected completion", run_en_o);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule